// File: doc/BRIEF.md
# Cascaded Decimal Digit Adder

This block adds two packed decimal numbers, each held as a row of 4-bit digit codes, plus a single carry bit entering at the least significant digit. It is purely combinational. Each digit position has its own slice. The slice first adds its two digits and the incoming carry as ordinary binary, then repairs that binary result into a legal decimal digit and a decimal carry.

The decimal carry of each slice feeds the binary carry input of the next more significant slice. The carry leaving the most significant slice is a leading half-digit that can only be 0 or 1. With the default four digits, the whole result spans 0 to 19999.

The digit count is a parameter. A second parameter selects the form of the internal 4-bit binary adders: a chain of full-adder cells, or a single behavioural addition. Behaviour is defined only when every operand digit lies in 0..9.

Top module: `bcd_cascade_adder`

## Requirements
- R1: Each slice forms a 5-bit raw binary sum of its two digits and its incoming carry; the binary carry out is bit 4.
- R2: A slice's decimal carry is 1 exactly when its raw sum is 10 or more, and 0 when it is 9 or less.
- R3: When the raw sum is 9 or less, the slice's output digit equals the raw sum unchanged.
- R4: When the raw sum is 10 or more, the output digit is the low four raw bits plus 6, taken modulo 16. The carry of that correcting addition is discarded, so the digit equals the raw sum minus 10.
- R5: The decimal carry of digit k enters the binary adder of digit k+1, so a carry can ripple through every digit (for example 9999 + 0 with carry-in 1 gives 10000).
- R6: The top carry_out is the half-digit of the result. For four digits the result reaches its maximum of 19999 at 9999 + 9999 with carry-in 1.
- R7: carry_in is added at the units digit with weight 1.
- R8: Operands and sum are packed with the units digit in bits [3:0], tens in [7:4], and each further digit in the next higher nibble. The result value is carry_out * 10^N plus the packed sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addend_a | input | 4*NUM_DIGITS | First packed decimal operand, units digit in [3:0] |
| addend_b | input | 4*NUM_DIGITS | Second packed decimal operand, units digit in [3:0] |
| carry_in | input | 1 | Carry into the units digit |
| sum_bcd | output | 4*NUM_DIGITS | Packed decimal sum digits |
| carry_out | output | 1 | Leading half-digit of the result |

## Verification
The hardest case to reach from the ports is a carry that must ripple through every slice. It needs each higher digit pair to sum to exactly nine, so that a slice raises its carry only because a carry arrived from below. Every single-digit pair, with both carry-in values, is swept at each digit position in turn. Directed vectors such as 9999 + 0 + 1, 4567 + 5432 + 1 and 9999 + 9999 + 1 force a full-length ripple and the maximum result. Random packed vectors then mix carries and non-carries across the positions.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

   localparam int unsigned DIGIT_W   = 4;
   localparam int unsigned DIGIT_MAX = 9;
   localparam int unsigned RADIX     = 10;

   typedef logic [DIGIT_W-1:0] bcd_digit_t;
   typedef logic [DIGIT_W:0]   raw_sum_t;

   function automatic logic is_decimal(input bcd_digit_t d);
      return (int'(d) <= DIGIT_MAX);
   endfunction

endpackage

// File: rtl/bcd_nibble_add.sv
module bcd_nibble_add #(
   parameter int unsigned WIDTH  = 4,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   input  logic             cin,
   output logic [WIDTH:0]   total
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bcd_nibble_add: WIDTH must be at least 1");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         logic half;
         assign half       = op_x[i] ^ op_y[i];
         assign total[i]   = half ^ chain[i];
         assign chain[i+1] = (op_x[i] & op_y[i]) | (half & chain[i]);
      end
      assign total[WIDTH] = chain[WIDTH];
   end else begin : g_behav
      assign total = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, cin};
   end

endmodule

// File: rtl/bcd_decimal_carry.sv
module bcd_decimal_carry
   import bcd_add_pkg::*;
(
   input  raw_sum_t raw,
   output logic     dec_carry
);

   // Sums 16..19 show up on the binary carry. Sums 10..15 have bit 3 set
   // together with bit 2 or bit 1.
   assign dec_carry = raw[4] | (raw[3] & raw[2]) | (raw[3] & raw[1]);

endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
   import bcd_add_pkg::*;
#(
   parameter bit RIPPLE = 1'b1
) (
   input  bcd_digit_t dig_a,
   input  bcd_digit_t dig_b,
   input  logic       cin,
   output bcd_digit_t dig_sum,
   output logic       cout
);

   raw_sum_t   raw;
   raw_sum_t   fixed;
   logic       dec_c;
   bcd_digit_t corr;

   bcd_nibble_add #(.WIDTH(DIGIT_W), .RIPPLE(RIPPLE)) u_bin (
      .op_x (dig_a),
      .op_y (dig_b),
      .cin  (cin),
      .total(raw)
   );

   bcd_decimal_carry u_dc (
      .raw      (raw),
      .dec_carry(dec_c)
   );

   // Correction operand: 0000 or 0110
   assign corr = {1'b0, dec_c, dec_c, 1'b0};

   bcd_nibble_add #(.WIDTH(DIGIT_W), .RIPPLE(RIPPLE)) u_fix (
      .op_x (raw[DIGIT_W-1:0]),
      .op_y (corr),
      .cin  (1'b0),
      .total(fixed)
   );

   assign dig_sum = fixed[DIGIT_W-1:0];
   assign cout    = dec_c;

   always_comb begin
      if (is_decimal(dig_a) && is_decimal(dig_b)) begin
         a_r1_raw_sum: assert (int'(raw) == int'(dig_a) + int'(dig_b) + int'(cin))
            else $error("R1 raw sum mismatch");
         a_r2_dec_carry: assert (cout == (int'(raw) >= int'(RADIX)))
            else $error("R2 decimal carry mismatch");
         if (int'(raw) < int'(RADIX)) begin
            a_r3_passthrough: assert (dig_sum == raw[DIGIT_W-1:0])
               else $error("R3 digit altered");
         end else begin
            a_r4_corrected: assert (int'(dig_sum) == int'(raw) - int'(RADIX))
               else $error("R4 corrected digit wrong");
         end
         // The discarded carry of the fix-up adder appears only for raw 10..15
         a_r4_discard: assert (fixed[DIGIT_W] == (dec_c & ~raw[DIGIT_W]))
            else $error("R4 fix-up carry unexpected");
      end
   end

endmodule

// File: rtl/bcd_cascade_adder.sv
module bcd_cascade_adder
   import bcd_add_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 4,
   parameter bit          RIPPLE_ADD = 1'b1
) (
   input  logic [NUM_DIGITS*4-1:0] addend_a,
   input  logic [NUM_DIGITS*4-1:0] addend_b,
   input  logic                    carry_in,
   output logic [NUM_DIGITS*4-1:0] sum_bcd,
   output logic                    carry_out
);

   localparam int unsigned VEC_W = NUM_DIGITS * DIGIT_W;

   if (NUM_DIGITS < 1) begin : g_bad_digits
      $error("bcd_cascade_adder: NUM_DIGITS must be at least 1");
   end
   if (VEC_W != NUM_DIGITS * 4) begin : g_bad_pack
      $error("bcd_cascade_adder: digit width must be 4");
   end

   logic [NUM_DIGITS:0] dcarry;
   assign dcarry[0] = carry_in;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      bcd_digit_slice #(.RIPPLE(RIPPLE_ADD)) u_slice (
         .dig_a  (addend_a[k*DIGIT_W +: DIGIT_W]),
         .dig_b  (addend_b[k*DIGIT_W +: DIGIT_W]),
         .cin    (dcarry[k]),
         .dig_sum(sum_bcd[k*DIGIT_W +: DIGIT_W]),
         .cout   (dcarry[k+1])
      );

      always_comb begin
         if (is_decimal(addend_a[k*DIGIT_W +: DIGIT_W]) &&
             is_decimal(addend_b[k*DIGIT_W +: DIGIT_W])) begin
            a_r5_digit_legal: assert (is_decimal(sum_bcd[k*DIGIT_W +: DIGIT_W]))
               else $error("R5 output digit out of range");
            if (addend_a[k*DIGIT_W +: DIGIT_W] == 4'd9 &&
                addend_b[k*DIGIT_W +: DIGIT_W] == 4'd9) begin
               a_r5_forces_carry: assert (dcarry[k+1] == 1'b1)
                  else $error("R5 9+9 did not carry");
            end
         end
      end
   end

   assign carry_out = dcarry[NUM_DIGITS];

endmodule

// File: tb/bcd_cascade_adder_bench.sv
module bcd_cascade_adder_bench;

   localparam int ND = 4;
   localparam int W  = ND * 4;
   localparam int LIMIT = 10000;

   logic         clk = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         c_in = 1'b0;
   logic [W-1:0] s_out;
   logic         c_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bcd_cascade_adder #(.NUM_DIGITS(ND), .RIPPLE_ADD(1'b1)) u_bcd_cascade_adder (
      .addend_a (a_in),
      .addend_b (b_in),
      .carry_in (c_in),
      .sum_bcd  (s_out),
      .carry_out(c_out)
   );

   function automatic logic [W-1:0] to_bcd(input int v);
      logic [W-1:0] r = '0;
      int t = v;
      for (int i = 0; i < ND; i++) begin
         r[i*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   function automatic int from_bcd(input logic [W-1:0] v);
      int r = 0;
      for (int i = ND - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
      return r;
   endfunction

   task automatic apply(input int av, input int bv, input logic cv, input string tag);
      int tot;
      @(posedge clk);
      a_in <= to_bcd(av);
      b_in <= to_bcd(bv);
      c_in <= cv;
      @(negedge clk);
      tot = av + bv + int'(cv);
      checks++;
      if (s_out !== to_bcd(tot % LIMIT) || c_out !== (tot >= LIMIT)) begin
         errors++;
         $display("FAIL %s: %0d+%0d+%0d got carry=%0b sum=%h expected carry=%0b sum=%h",
                  tag, av, bv, cv, c_out, s_out, (tot >= LIMIT), to_bcd(tot % LIMIT));
      end
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int scale;
      int ra;
      int rb;
      // Idle state: all-zero inputs give a zero result
      apply(0, 0, 1'b0, "R8 zero");
      // R2 R3 R4 R7: every digit pair with both carry-in values, at each position
      for (int p = 0; p < ND; p++) begin
         scale = 1;
         for (int q = 0; q < p; q++) scale = scale * 10;
         for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
               for (int c = 0; c < 2; c++)
                  apply(x * scale, y * scale, 1'(c), "R2 R3 R4 R7 digit sweep");
      end
      // R5: full-length ripple
      apply(9999, 0, 1'b1, "R5 ripple 9999+1");
      apply(4567, 5432, 1'b1, "R5 ripple nines");
      apply(909, 90, 1'b1, "R5 alternating ripple");
      // R6: half-digit and maximum result
      apply(9999, 9999, 1'b1, "R6 max 19999");
      apply(5000, 5000, 1'b0, "R6 exact 10000");
      apply(9999, 0, 1'b0, "R6 no carry 9999");
      // R1 R8: random packed vectors
      for (int n = 0; n < 400; n++) begin
         ra = int'($urandom % 10000);
         rb = int'($urandom % 10000);
         apply(ra, rb, 1'($urandom % 2), "R1 R8 random");
      end
      summary();
   end

   initial begin
      if (from_bcd(to_bcd(1234)) != 1234) $display("bench helper self-test mismatch");
   end

endmodule